// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block supervises a battery-backed static memory. It reads two digitized supply-level flags from external comparators. The upper flag is high while the supply is above the write-protect threshold. The lower flag is high while the supply is above the battery switchover level. From these two flags the block decides, on every clock, whether the memory may be accessed, whether its data outputs must float, and whether the memory core runs from the external supply or from the backup cell.

Protection is applied the moment the flags fall, with no filtering. Leaving protection is slower. The flags must be seen high and steady for a debounce window, and then a recovery lockout must run out, before accesses are released. A one-time seal keeps the backup cell disconnected from reset until the supply has been properly up once. After that, battery backup stays armed for good.

Top module: `pfail_guard`

## Requirements
- R1: After reset, `wr_block` = 1, `out_hiz` = 1, `bat_sel` = 0 and `seal_intact` = 1.
- R2: While `seal_intact` = 1, `bat_sel` stays 0 whatever the flags do. `seal_intact` falls only after both flags have been high for the debounce window.
- R3: Once `seal_intact` is 0 it stays 0 until the next reset. From then on, a later loss of supply selects the battery.
- R4: When `supply_above_prot` has been low for three consecutive clock samples, `wr_block` and `out_hiz` are 1 in the next cycle. No debounce applies to this path.
- R5: With the seal broken, when both flags have been low for three consecutive samples, `bat_sel` = 1 in the next cycle. While `bat_sel` = 1, `wr_block` and `out_hiz` are also 1.
- R6: A return of `supply_above_swo` to 1 while `supply_above_prot` stays 0 clears `bat_sel` only after the debounce window. Protection stays asserted.
- R7: The flag combination `supply_above_prot` = 1 with `supply_above_swo` = 0 is treated as the protected level. This means `wr_block` = 1 and `bat_sel` = 0, it takes effect without debounce, and it does not break the seal.
- R8: After both flags rise, `wr_block` and `out_hiz` fall no earlier than DEBOUNCE_CYCLES + RECOVERY_CYCLES cycles later, and no later than DEBOUNCE_CYCLES + RECOVERY_CYCLES + 10 cycles later.
- R9: A high pulse on both flags shorter than the debounce window neither starts recovery nor breaks the seal.
- R10: A dip below the write-protect level during the recovery lockout restarts the lockout. The full recovery time is counted again from the return of the supply.
- R11: `out_hiz` equals `wr_block` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| supply_above_prot | input | 1 | Asynchronous comparator flag: supply above write-protect threshold |
| supply_above_swo | input | 1 | Asynchronous comparator flag: supply above battery switchover level |
| wr_block | output | 1 | 1 = memory chip enables forced inactive, writes blocked |
| out_hiz | output | 1 | 1 = memory data outputs forced to high impedance |
| bat_sel | output | 1 | 1 = memory core powered from the backup cell |
| seal_intact | output | 1 | 1 = backup cell still disconnected since reset |

## Verification
The bench drives the seal with a short glitch and with the illegal flag pair. A design that broke the seal on an unfiltered or illegal flag would arm the battery too early. It then measures the release time against both bounds of the debounce-plus-lockout window. A design that skipped the lockout, or failed to restart it after a dip during recovery, would release accesses early. It also times the fall into protection and into battery mode after a few cycles. A design that filtered the falling edge would leave writes open while the supply collapses. A battery exit that was not debounced would drop `bat_sel` within a few cycles of the lower flag rising.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  // Supply level classes, ordered so that a lower value is a worse supply
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_PROT = 2'd1,
    LVL_OK   = 2'd2
  } lvl_e;

  typedef enum logic [2:0] {
    ST_SEALED     = 3'd0,
    ST_POWERED    = 3'd1,
    ST_PROTECTED  = 3'd2,
    ST_BATTERY    = 3'd3,
    ST_RECOVERING = 3'd4
  } st_e;

  // Both flags high: full function. Both low: below switchover.
  // Anything else, including the impossible pair, counts as protected.
  function automatic lvl_e classify(input logic above_prot, input logic above_swo);
    if (above_prot && above_swo)        return LVL_OK;
    else if (!above_prot && !above_swo) return LVL_LOW;
    else                                return LVL_PROT;
  endfunction

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/pfg_level_filter.sv
module pfg_level_filter
  import pfg_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  lvl_e lvl_raw,
  output lvl_e lvl_use
);

  localparam int DW = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
  localparam logic [DW-1:0] LAST = DW'(DEBOUNCE_CYCLES - 1);

  lvl_e          lvl_held;
  lvl_e          lvl_cand;
  logic [DW-1:0] cnt;

  // Downgrades are taken at once; upgrades need a steady run of samples
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_held <= LVL_LOW;
      lvl_cand <= LVL_LOW;
      cnt      <= '0;
    end else begin
      lvl_cand <= lvl_raw;
      if (lvl_raw < lvl_held) begin
        lvl_held <= lvl_raw;
        cnt      <= '0;
      end else if ((lvl_raw == lvl_held) || (lvl_raw != lvl_cand)) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        lvl_held <= lvl_raw;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // The worse of the live sample and the held level drives the sequencer,
  // so a falling supply bypasses the filter register
  always_comb begin
    if (lvl_raw < lvl_held) lvl_use = lvl_raw;
    else                    lvl_use = lvl_held;
  end

endmodule

// File: rtl/pfg_lockout.sv
module pfg_lockout #(
  parameter int RECOVERY_CYCLES = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);

  localparam int CW = (RECOVERY_CYCLES > 1) ? $clog2(RECOVERY_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(RECOVERY_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  // Leaving the recovery state clears the count, so any re-entry restarts it
  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!done)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pfg_fsm.sv
module pfg_fsm
  import pfg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  lvl_e lvl_use,
  input  logic lock_done,
  output logic recovering,
  output logic wr_block,
  output logic out_hiz,
  output logic bat_sel,
  output logic seal_intact
);

  st_e  st_q;
  st_e  st_nxt;
  logic seal_q;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_SEALED: begin
        if (lvl_use == LVL_OK) st_nxt = ST_RECOVERING;
      end
      ST_RECOVERING: begin
        if (lvl_use == LVL_LOW)       st_nxt = ST_BATTERY;
        else if (lvl_use == LVL_PROT) st_nxt = ST_PROTECTED;
        else if (lock_done)           st_nxt = ST_POWERED;
      end
      ST_POWERED: begin
        if (lvl_use == LVL_LOW)       st_nxt = ST_BATTERY;
        else if (lvl_use == LVL_PROT) st_nxt = ST_PROTECTED;
      end
      ST_PROTECTED: begin
        if (lvl_use == LVL_LOW)       st_nxt = ST_BATTERY;
        else if (lvl_use == LVL_OK)   st_nxt = ST_RECOVERING;
      end
      ST_BATTERY: begin
        if (lvl_use == LVL_PROT)      st_nxt = ST_PROTECTED;
        else if (lvl_use == LVL_OK)   st_nxt = ST_RECOVERING;
      end
      default: st_nxt = ST_SEALED;
    endcase
  end

  // Outputs are registered from the next state so they change in the
  // same cycle as the state register
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_SEALED;
      seal_q   <= 1'b1;
      wr_block <= 1'b1;
      out_hiz  <= 1'b1;
      bat_sel  <= 1'b0;
    end else begin
      st_q     <= st_nxt;
      if (st_q == ST_SEALED && st_nxt != ST_SEALED) seal_q <= 1'b0;
      wr_block <= (st_nxt != ST_POWERED);
      out_hiz  <= (st_nxt != ST_POWERED);
      bat_sel  <= (st_nxt == ST_BATTERY);
    end
  end

  assign recovering  = (st_q == ST_RECOVERING);
  assign seal_intact = seal_q;

endmodule

// File: rtl/pfail_guard.sv
module pfail_guard
  import pfg_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 16,
  parameter int RECOVERY_CYCLES = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_above_prot,
  input  logic supply_above_swo,
  output logic wr_block,
  output logic out_hiz,
  output logic bat_sel,
  output logic seal_intact
);

  localparam int NFLAGS = 2;

  logic [NFLAGS-1:0] flags_sync;
  lvl_e              lvl_raw;
  lvl_e              lvl_use;
  logic              recovering;
  logic              lock_done;

  pfg_sync #(
    .WIDTH  (NFLAGS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({supply_above_prot, supply_above_swo}),
    .q_sync  (flags_sync)
  );

  assign lvl_raw = classify(flags_sync[1], flags_sync[0]);

  pfg_level_filter #(
    .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES)
  ) u_filter (
    .clk     (clk),
    .rst     (rst),
    .lvl_raw (lvl_raw),
    .lvl_use (lvl_use)
  );

  pfg_lockout #(
    .RECOVERY_CYCLES (RECOVERY_CYCLES)
  ) u_lockout (
    .clk  (clk),
    .rst  (rst),
    .run  (recovering),
    .done (lock_done)
  );

  pfg_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .lvl_use     (lvl_use),
    .lock_done   (lock_done),
    .recovering  (recovering),
    .wr_block    (wr_block),
    .out_hiz     (out_hiz),
    .bat_sel     (bat_sel),
    .seal_intact (seal_intact)
  );

endmodule

// File: rtl/pfg_checker.sv
module pfg_checker (
  input logic clk,
  input logic rst,
  input logic supply_above_prot,
  input logic supply_above_swo,
  input logic wr_block,
  input logic out_hiz,
  input logic bat_sel,
  input logic seal_intact
);

  // R2: no battery while the seal is intact
  assert_no_bat_when_sealed_R2: assert property (@(posedge clk) disable iff (rst)
    bat_sel |-> !seal_intact);

  // R3: a broken seal stays broken
  assert_seal_permanent_R3: assert property (@(posedge clk) disable iff (rst)
    !seal_intact |=> !seal_intact);

  // R4: protection follows a low protect flag without debounce
  assert_protect_fast_R4: assert property (@(posedge clk) disable iff (rst)
    (!supply_above_prot && $past(!supply_above_prot) && $past(!supply_above_prot, 2))
    |=> wr_block);

  // R5: battery mode also blocks and floats
  assert_bat_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    bat_sel |-> (wr_block && out_hiz));

  // R5: low supply with a broken seal selects the battery
  assert_bat_fast_R5: assert property (@(posedge clk) disable iff (rst)
    (!seal_intact && !supply_above_prot && !supply_above_swo &&
     $past(!supply_above_prot && !supply_above_swo) &&
     $past(!supply_above_prot && !supply_above_swo, 2))
    |=> bat_sel);

  // R8: release only follows a good supply sample
  assert_release_needs_ok_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_block) |-> $past(supply_above_prot && supply_above_swo, 3));

  // R11: block and float move together
  assert_hiz_tracks_block_R11: assert property (@(posedge clk) disable iff (rst)
    out_hiz == wr_block);

endmodule

bind pfail_guard pfg_checker u_pfg_checker (
  .clk               (clk),
  .rst               (rst),
  .supply_above_prot (supply_above_prot),
  .supply_above_swo  (supply_above_swo),
  .wr_block          (wr_block),
  .out_hiz           (out_hiz),
  .bat_sel           (bat_sel),
  .seal_intact       (seal_intact)
);

// File: tb/tb_pfail_guard.sv
`timescale 1ns/1ps
module tb_pfail_guard;

  localparam int DEB = 8;
  localparam int REC = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prot = 1'b0;
  logic swo = 1'b0;
  logic wr_block, out_hiz, bat_sel, seal_intact;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pfail_guard #(
    .SYNC_STAGES     (2),
    .DEBOUNCE_CYCLES (DEB),
    .RECOVERY_CYCLES (REC)
  ) dut (
    .clk               (clk),
    .rst               (rst),
    .supply_above_prot (prot),
    .supply_above_swo  (swo),
    .wr_block          (wr_block),
    .out_hiz           (out_hiz),
    .bat_sel           (bat_sel),
    .seal_intact       (seal_intact)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(1);
    chk("R1", "wr_block", wr_block, 1'b1);
    chk("R1", "out_hiz", out_hiz, 1'b1);
    chk("R1", "bat_sel", bat_sel, 1'b0);
    chk("R1", "seal_intact", seal_intact, 1'b1);
  endtask

  task automatic t_sealed_low;
    wait_cyc(30);
    chk("R2", "bat_sel sealed low", bat_sel, 1'b0);
    chk("R2", "seal kept low supply", seal_intact, 1'b1);
  endtask

  task automatic t_illegal_sealed;
    prot = 1'b1; swo = 1'b0;
    wait_cyc(40);
    chk("R7", "seal kept illegal pair", seal_intact, 1'b1);
    chk("R7", "wr_block illegal pair", wr_block, 1'b1);
    chk("R7", "bat_sel illegal pair", bat_sel, 1'b0);
    prot = 1'b0;
    wait_cyc(10);
  endtask

  task automatic t_glitch;
    prot = 1'b1; swo = 1'b1;
    wait_cyc(DEB - 3);
    prot = 1'b0; swo = 1'b0;
    wait_cyc(60);
    chk("R9", "seal kept after glitch", seal_intact, 1'b1);
    chk("R9", "wr_block after glitch", wr_block, 1'b1);
  endtask

  task automatic t_powerup;
    prot = 1'b1; swo = 1'b1;
    wait_cyc(DEB + REC - 1);
    chk("R8", "wr_block before lockout end", wr_block, 1'b1);
    chk("R11", "out_hiz before lockout end", out_hiz, 1'b1);
    chk("R2", "seal broken after good supply", seal_intact, 1'b0);
    wait_cyc(11);
    chk("R8", "wr_block released", wr_block, 1'b0);
    chk("R11", "out_hiz released", out_hiz, 1'b0);
  endtask

  task automatic t_protect_fast;
    prot = 1'b0;
    wait_cyc(4);
    chk("R4", "wr_block fast", wr_block, 1'b1);
    chk("R4", "out_hiz fast", out_hiz, 1'b1);
    chk("R4", "bat_sel protected", bat_sel, 1'b0);
  endtask

  task automatic t_battery;
    swo = 1'b0;
    wait_cyc(4);
    chk("R5", "bat_sel fast", bat_sel, 1'b1);
    chk("R5", "wr_block on battery", wr_block, 1'b1);
  endtask

  task automatic t_return;
    swo = 1'b1;
    wait_cyc(4);
    chk("R6", "bat_sel held during debounce", bat_sel, 1'b1);
    wait_cyc(DEB + 8);
    chk("R6", "bat_sel cleared", bat_sel, 1'b0);
    chk("R6", "wr_block still set", wr_block, 1'b1);
  endtask

  task automatic t_dip_restart;
    prot = 1'b1;
    wait_cyc(DEB + 20);
    chk("R10", "wr_block mid recovery", wr_block, 1'b1);
    prot = 1'b0;
    wait_cyc(3);
    prot = 1'b1;
    wait_cyc(DEB + REC - 1);
    chk("R10", "lockout restarted", wr_block, 1'b1);
    wait_cyc(11);
    chk("R10", "released after restart", wr_block, 1'b0);
  endtask

  task automatic t_illegal_powered;
    prot = 1'b1; swo = 1'b0;
    wait_cyc(4);
    chk("R7", "wr_block illegal from powered", wr_block, 1'b1);
    chk("R7", "bat_sel illegal from powered", bat_sel, 1'b0);
  endtask

  task automatic t_seal_permanent;
    prot = 1'b0; swo = 1'b0;
    wait_cyc(4);
    chk("R3", "battery armed after seal", bat_sel, 1'b1);
    chk("R3", "seal still broken", seal_intact, 1'b0);
  endtask

  initial begin
    t_reset();
    t_sealed_low();
    t_illegal_sealed();
    t_glitch();
    t_powerup();
    t_protect_fast();
    t_battery();
    t_return();
    t_dip_restart();
    t_illegal_powered();
    t_seal_permanent();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule